// File: doc/BRIEF.md
# Byte-to-Word DMA Staging Buffer

This block sits between an 8-bit SCSI controller byte port and a 16-bit DMA master. On a receive it collects bytes from the controller, joins each pair into a word with the earlier byte in the upper half, and offers the words to the DMA engine through a request/acknowledge port. On a send it fetches words from the DMA engine and hands their bytes to the controller, upper byte first.

Software loads a down-counting byte count, sets the direction and enables the SCSI side. The block moves exactly that many bytes. The DMA-side word count it reports is half the byte count, rounded up for a send. On an odd-length receive the final lone byte never becomes a DMA word. The data register always holds the two most recent received bytes, so software can recover the tail byte. When the count reaches zero the block raises a DMA-pending status bit, and it can raise an interrupt. A control bit held low clears the word queue without disturbing the byte count.

Top module: `dma_byte_stager`

## Requirements
- R1: After reset the control/status register reads 0x0400, and the byte count, data and word-count registers read 0. `irq` and `wreq` are low and `fifo_empty` is high. Register map: address 0 control/status, 1 byte count (read/write), 2 data, 3 DMA word count (read only).
- R2: Control/status bit 1 low holds the word queue empty. Clearing the bit and then setting it again leaves the queue empty, status bit 10 set and `wreq` low, and the byte count unchanged.
- R3: A value written to the byte count register reads back unchanged while the SCSI-side enable (bit 0) is low. No byte is accepted or offered while that enable is low.
- R4: While the block is enabled and running, the byte count drops by one for each byte that moves on the byte port. At zero, no further byte is accepted or offered.
- R5: The word-count register reads the byte count divided by two. In send mode (bit 3 = 1) an odd byte count adds one word.
- R6: Receive (bit 3 = 0): byte 2k goes to bits 15:8 and byte 2k+1 to bits 7:0 of word k. `wreq` stays high while at least one complete word is queued, and each `wack` cycle takes one word from `wdata_out`.
- R7: On an odd-length receive the final byte is not delivered as a DMA word. The data register then reads {second-to-last byte, last byte}.
- R8: Send: the block requests exactly ceil(N/2) words for N bytes. Each word gives its upper byte first. On an odd count the lower byte of the last word is discarded.
- R9: Status bit 10 reads 1 when no data (whole or half word) is held. Bit 9 mirrors `sbc_irq`. Bit 8 sets when the byte count reaches zero through a transfer, and it clears on a write to the byte count register or while bit 1 is low.
- R10: `irq` is high exactly when the interrupt enable (bit 2) is set and status bit 8 or bit 9 is set.
- R11: If the SCSI-side enable is cleared mid-transfer, the byte count register reads the residual number of bytes not yet moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on address) |
| sbc_irq | input | 1 | Interrupt level from the SCSI controller |
| irq | output | 1 | Interrupt output |
| byte_in_valid | input | 1 | Controller offers a received byte |
| byte_in | input | 8 | Received byte |
| byte_in_ready | output | 1 | Block accepts the received byte |
| byte_out_valid | output | 1 | Block offers a byte to send |
| byte_out | output | 8 | Byte to send |
| byte_out_take | input | 1 | Controller takes the offered byte |
| wreq | output | 1 | Word request to the DMA engine |
| wack | input | 1 | DMA engine completes one word this cycle |
| wdata_in | input | 16 | Word from memory (send) |
| wdata_out | output | 16 | Word to memory (receive) |
| fifo_empty | output | 1 | No whole or half word held |

## Verification
Transfers of every length from 1 to 9 bytes are swept in both directions, with the expected words and bytes computed from the length alone. A design that paired bytes in the wrong order, pushed an odd tail byte as a word, or fetched one word too few or too many on an odd send shows up as a wrong word, a wrong byte or a wrong count. Separate cases check three things: that a queue reset flushes a held word without touching the byte count, that a stopped transfer reports its residual, and that the pending bit and the interrupt follow count writes and `sbc_irq`. A design that cleared the count on queue reset, or left `irq` ungated by the enable, fails one of these.

// File: rtl/dbf_pkg.sv
`timescale 1ns/1ps
package dbf_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RA_CSR   = 2'd0,
    RA_COUNT = 2'd1,
    RA_DATA  = 2'd2,
    RA_WORDS = 2'd3
  } dbf_reg_e;

  localparam int B_SCSI_EN  = 0;
  localparam int B_FIFO_RUN = 1;
  localparam int B_IRQ_EN   = 2;
  localparam int B_SEND     = 3;
  localparam int B_DMA_PEND = 8;
  localparam int B_SBC_PEND = 9;
  localparam int B_EMPTY    = 10;

  // DMA-side word count for a byte count; odd sends round up
  function automatic logic [WORD_W-1:0] words_for(input logic [WORD_W-1:0] bytes,
                                                  input logic send);
    return (bytes >> 1) + {{(WORD_W-1){1'b0}}, send & bytes[0]};
  endfunction
endpackage

// File: rtl/dbf_word_fifo.sv
`timescale 1ns/1ps
module dbf_word_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);

  a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/dbf_packer.sv
`timescale 1ns/1ps
module dbf_packer
  import dbf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scsi_en,
  input  logic              fifo_run,
  input  logic              send,
  input  logic              cnt_load,
  input  logic [WORD_W-1:0] cnt_wdata,
  input  logic              byte_in_valid,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              byte_in_ready,
  output logic              byte_out_valid,
  output logic [BYTE_W-1:0] byte_out,
  input  logic              byte_out_take,
  output logic              wreq,
  input  logic              wack,
  input  logic [WORD_W-1:0] wdata_in,
  output logic [WORD_W-1:0] wdata_out,
  output logic              f_push,
  output logic [WORD_W-1:0] f_din,
  output logic              f_pop,
  input  logic [WORD_W-1:0] f_dout,
  input  logic              f_full,
  input  logic              f_empty,
  output logic [WORD_W-1:0] byte_cnt,
  output logic [WORD_W-1:0] residue,
  output logic [WORD_W-1:0] words,
  output logic              drained,
  output logic              done_evt
);
  logic [WORD_W-1:0] fetch_left;
  logic [BYTE_W-1:0] hi_hold;
  logic              phase;
  logic              active, last_byte, rx_fire, tx_fire, byte_fire, word_fire;

  assign last_byte      = (byte_cnt == WORD_W'(1));
  assign active         = scsi_en & fifo_run & (byte_cnt != '0);
  assign byte_in_ready  = !send & active & !f_full;
  assign rx_fire        = byte_in_valid & byte_in_ready;
  assign byte_out_valid = send & active & !f_empty;
  assign byte_out       = phase ? f_dout[BYTE_W-1:0] : f_dout[WORD_W-1:BYTE_W];
  assign tx_fire        = byte_out_valid & byte_out_take;
  assign byte_fire      = rx_fire | tx_fire;

  assign wreq      = fifo_run & (send ? ((fetch_left != '0) & !f_full) : !f_empty);
  assign word_fire = wack & wreq;
  assign f_push    = send ? word_fire : (rx_fire & phase);
  assign f_din     = send ? wdata_in : {hi_hold, byte_in};
  assign f_pop     = send ? (tx_fire & (phase | last_byte)) : word_fire;
  assign wdata_out = f_dout;

  assign words    = words_for(byte_cnt, send);
  assign drained  = f_empty & !phase;
  assign done_evt = byte_fire & last_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_cnt   <= '0;
      fetch_left <= '0;
      phase      <= 1'b0;
      hi_hold    <= '0;
      residue    <= '0;
    end else begin
      if (cnt_load)       byte_cnt <= cnt_wdata;
      else if (byte_fire) byte_cnt <= byte_cnt - 1'b1;

      if (cnt_load)                   fetch_left <= words_for(cnt_wdata, send);
      else if (send && word_fire)     fetch_left <= fetch_left - 1'b1;

      if (!fifo_run)      phase <= 1'b0;
      else if (byte_fire) phase <= !phase & !last_byte;

      if (rx_fire && !phase) hi_hold <= byte_in;
      if (rx_fire)           residue <= {residue[BYTE_W-1:0], byte_in};
    end
  end

  a_r3_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_load && !scsi_en) |=> $stable(byte_cnt));
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_fire && !cnt_load) |=> (byte_cnt == $past(byte_cnt) - 1'b1));
  a_r4_zero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_cnt == '0) |-> (!byte_in_ready && !byte_out_valid));
  a_r7_tail_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fire |=> (residue[BYTE_W-1:0] == $past(byte_in)));
endmodule

// File: rtl/dbf_csr.sv
`timescale 1ns/1ps
module dbf_csr
  import dbf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              sbc_irq,
  input  logic              done_evt,
  input  logic              drained,
  input  logic [WORD_W-1:0] byte_cnt,
  input  logic [WORD_W-1:0] residue,
  input  logic [WORD_W-1:0] words,
  output logic              scsi_en,
  output logic              fifo_run,
  output logic              irq_en,
  output logic              send,
  output logic              cnt_load,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq
);
  logic [3:0]        ctl;
  logic              dma_pend;
  logic [WORD_W-1:0] status;

  assign scsi_en  = ctl[B_SCSI_EN];
  assign fifo_run = ctl[B_FIFO_RUN];
  assign irq_en   = ctl[B_IRQ_EN];
  assign send     = ctl[B_SEND];
  assign cnt_load = reg_we && (reg_addr == RA_COUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl      <= '0;
      dma_pend <= 1'b0;
    end else begin
      if (reg_we && reg_addr == RA_CSR) ctl <= reg_wdata[3:0];
      if (cnt_load || !fifo_run) dma_pend <= 1'b0;
      else if (done_evt)         dma_pend <= 1'b1;
    end
  end

  always_comb begin
    status             = '0;
    status[3:0]        = ctl;
    status[B_DMA_PEND] = dma_pend;
    status[B_SBC_PEND] = sbc_irq;
    status[B_EMPTY]    = drained;
  end

  always_comb begin
    case (reg_addr)
      RA_CSR:   reg_rdata = status;
      RA_COUNT: reg_rdata = byte_cnt;
      RA_DATA:  reg_rdata = residue;
      default:  reg_rdata = words;
    endcase
  end

  assign irq = irq_en & (dma_pend | sbc_irq);

  a_r9_pend_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !cnt_load && fifo_run) |=> status[B_DMA_PEND]);
  a_r9_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> !status[B_DMA_PEND]);
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
endmodule

// File: rtl/dma_byte_stager.sv
`timescale 1ns/1ps
module dma_byte_stager
  import dbf_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        sbc_irq,
  output logic        irq,
  input  logic        byte_in_valid,
  input  logic [7:0]  byte_in,
  output logic        byte_in_ready,
  output logic        byte_out_valid,
  output logic [7:0]  byte_out,
  input  logic        byte_out_take,
  output logic        wreq,
  input  logic        wack,
  input  logic [15:0] wdata_in,
  output logic [15:0] wdata_out,
  output logic        fifo_empty
);
  logic              scsi_en, fifo_run, irq_en, send, cnt_load;
  logic              f_push, f_pop, f_full, f_empty, drained, done_evt;
  logic [WORD_W-1:0] f_din, f_dout, byte_cnt, residue, words;

  dbf_csr u_csr (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sbc_irq(sbc_irq), .done_evt(done_evt),
    .drained(drained), .byte_cnt(byte_cnt), .residue(residue), .words(words),
    .scsi_en(scsi_en), .fifo_run(fifo_run), .irq_en(irq_en), .send(send),
    .cnt_load(cnt_load), .reg_rdata(reg_rdata), .irq(irq)
  );

  dbf_word_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(!fifo_run), .push(f_push), .din(f_din),
    .pop(f_pop), .dout(f_dout), .full(f_full), .empty(f_empty)
  );

  dbf_packer u_pack (
    .clk(clk), .rst_n(rst_n), .scsi_en(scsi_en), .fifo_run(fifo_run),
    .send(send), .cnt_load(cnt_load), .cnt_wdata(reg_wdata),
    .byte_in_valid(byte_in_valid), .byte_in(byte_in), .byte_in_ready(byte_in_ready),
    .byte_out_valid(byte_out_valid), .byte_out(byte_out), .byte_out_take(byte_out_take),
    .wreq(wreq), .wack(wack), .wdata_in(wdata_in), .wdata_out(wdata_out),
    .f_push(f_push), .f_din(f_din), .f_pop(f_pop), .f_dout(f_dout),
    .f_full(f_full), .f_empty(f_empty), .byte_cnt(byte_cnt), .residue(residue),
    .words(words), .drained(drained), .done_evt(done_evt)
  );

  assign fifo_empty = drained;

  a_r2_held_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_run |-> (!wreq && !byte_in_ready && !byte_out_valid));
  a_r6_ack_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    (wack && !send) |-> wreq);
endmodule

// File: tb/test_dma_byte_stager.sv
`timescale 1ns/1ps
module test_dma_byte_stager;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        sbc_irq = 1'b0;
  logic        irq;
  logic        byte_in_valid = 1'b0;
  logic [7:0]  byte_in = 8'h0;
  logic        byte_in_ready;
  logic        byte_out_valid;
  logic [7:0]  byte_out;
  logic        byte_out_take = 1'b0;
  logic        wreq;
  logic        wack = 1'b0;
  logic [15:0] wdata_in = 16'h0;
  logic [15:0] wdata_out;
  logic        fifo_empty;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_byte_stager i_dma_byte_stager (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sbc_irq(sbc_irq), .irq(irq),
    .byte_in_valid(byte_in_valid), .byte_in(byte_in), .byte_in_ready(byte_in_ready),
    .byte_out_valid(byte_out_valid), .byte_out(byte_out), .byte_out_take(byte_out_take),
    .wreq(wreq), .wack(wack), .wdata_in(wdata_in), .wdata_out(wdata_out),
    .fifo_empty(fifo_empty)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [7:0] bval(input int n, input int i);
    return 8'(n * 16 + i * 3 + 1);
  endfunction

  function automatic logic [15:0] mval(input int i);
    return {8'(8'hA0 + i), 8'(8'h30 + i * 5)};
  endfunction

  // receive of n bytes, draining words as they appear
  task automatic run_rx(input int n);
    logic [15:0] got [16];
    logic [15:0] r;
    int sent = 0;
    int k = 0;
    reg_wr(2'd0, 16'h0000);
    reg_wr(2'd0, 16'h0002);
    reg_wr(2'd1, 16'(n));
    reg_rd(2'd1, r); chk($sformatf("R3 rx count readback n=%0d", n), r, 16'(n));
    reg_rd(2'd3, r); chk($sformatf("R5 rx words n=%0d", n), r, 16'(n / 2));
    reg_wr(2'd0, 16'h0003);
    for (int it = 0; it < 200; it++) begin
      wack = wreq;
      if (wreq && k < 16) begin got[k] = wdata_out; k++; end
      byte_in_valid = (sent < n);
      byte_in = bval(n, sent);
      #1;
      if (byte_in_valid && byte_in_ready) sent++;
      @(negedge clk);
      wack = 1'b0;
      byte_in_valid = 1'b0;
      if (sent == n && !wreq) break;
    end
    chk($sformatf("R4 rx bytes taken n=%0d", n), sent, n);
    chk($sformatf("R7 rx word total n=%0d", n), k, n / 2);
    for (int j = 0; j < n / 2; j++)
      chk($sformatf("R6 rx word %0d n=%0d", j, n), got[j], {bval(n, 2*j), bval(n, 2*j+1)});
    reg_rd(2'd1, r); chk($sformatf("R4 rx count zero n=%0d", n), r, 16'h0);
    if (n >= 2) begin
      reg_rd(2'd2, r);
      chk($sformatf("R7 rx data reg n=%0d", n), r, {bval(n, n-2), bval(n, n-1)});
    end
    reg_rd(2'd0, r);
    chk($sformatf("R9 rx status n=%0d", n), r, 16'h0503);
  endtask

  // send of n bytes, supplying words on request
  task automatic run_tx(input int n);
    logic [7:0] gb [20];
    logic [15:0] r;
    int f = 0;
    int g = 0;
    reg_wr(2'd0, 16'h0008);
    reg_wr(2'd0, 16'h000A);
    reg_wr(2'd1, 16'(n));
    reg_rd(2'd3, r); chk($sformatf("R5 tx words n=%0d", n), r, 16'((n + 1) / 2));
    reg_wr(2'd0, 16'h000B);
    byte_out_take = 1'b1;
    for (int it = 0; it < 200; it++) begin
      if (wreq) begin wack = 1'b1; wdata_in = mval(f); f++; end
      else wack = 1'b0;
      if (byte_out_valid && g < 20) begin gb[g] = byte_out; g++; end
      @(negedge clk);
      wack = 1'b0;
      if (g == n && !wreq) break;
    end
    byte_out_take = 1'b0;
    chk($sformatf("R8 tx words fetched n=%0d", n), f, (n + 1) / 2);
    chk($sformatf("R4 tx bytes sent n=%0d", n), g, n);
    for (int j = 0; j < n && j < 20; j++)
      chk($sformatf("R8 tx byte %0d n=%0d", j, n), gb[j],
          (j % 2 == 0) ? mval(j / 2) >> 8 : mval(j / 2) & 16'hFF);
    reg_rd(2'd1, r); chk($sformatf("R4 tx count zero n=%0d", n), r, 16'h0);
    reg_rd(2'd0, r); chk($sformatf("R9 tx status n=%0d", n), r, 16'h050B);
  endtask

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    reg_rd(2'd0, r); chk("R1 csr after reset", r, 16'h0400);
    reg_rd(2'd1, r); chk("R1 count after reset", r, 16'h0);
    reg_rd(2'd2, r); chk("R1 data after reset", r, 16'h0);
    reg_rd(2'd3, r); chk("R1 words after reset", r, 16'h0);
    chk("R1 outputs after reset", {irq, wreq, fifo_empty, byte_in_ready}, 4'b0010);

    // R3 readback with enable low, R5 word count rounding
    reg_wr(2'd0, 16'h0002);
    reg_wr(2'd1, 16'h1234);
    byte_in_valid = 1'b1; byte_in = 8'h5A;
    #1; chk("R3 no byte accepted when disabled", byte_in_ready, 1'b0);
    repeat (5) @(negedge clk);
    byte_in_valid = 1'b0;
    reg_rd(2'd1, r); chk("R3 count held", r, 16'h1234);
    reg_rd(2'd3, r); chk("R5 even recv words", r, 16'h091A);
    reg_wr(2'd0, 16'h000A);
    reg_rd(2'd3, r); chk("R5 even send words", r, 16'h091A);
    reg_wr(2'd1, 16'h1235);
    reg_rd(2'd3, r); chk("R5 odd send words", r, 16'h091B);
    reg_wr(2'd0, 16'h0002);
    reg_rd(2'd3, r); chk("R5 odd recv words", r, 16'h091A);

    // sweeps, R6 R7 R8
    for (int n = 1; n <= 9; n++) run_rx(n);
    for (int n = 1; n <= 9; n++) run_tx(n);

    // R11 residual and R2 queue reset
    reg_wr(2'd0, 16'h0000);
    reg_wr(2'd0, 16'h0002);
    reg_wr(2'd1, 16'd10);
    reg_wr(2'd0, 16'h0003);
    for (int s = 0, it = 0; s < 3 && it < 50; it++) begin
      byte_in_valid = 1'b1; byte_in = 8'(8'h70 + s);
      #1;
      if (byte_in_ready) s++;
      @(negedge clk);
      byte_in_valid = 1'b0;
    end
    reg_wr(2'd0, 16'h0002);
    reg_rd(2'd1, r); chk("R11 residual count", r, 16'd7);
    chk("R6 wreq with one word queued", wreq, 1'b1);
    reg_rd(2'd0, r); chk("R9 not empty while holding", r[10], 1'b0);
    reg_wr(2'd0, 16'h0000);
    chk("R2 wreq low in queue reset", wreq, 1'b0);
    reg_wr(2'd0, 16'h0002);
    reg_rd(2'd0, r); chk("R2 empty after reset pulse", r, 16'h0402);
    chk("R2 fifo_empty pin", fifo_empty, 1'b1);
    chk("R2 wreq after reset pulse", wreq, 1'b0);
    reg_rd(2'd1, r); chk("R2 count kept across queue reset", r, 16'd7);

    // R9 R10 interrupt behaviour
    sbc_irq = 1'b1;
    #1; chk("R10 irq masked", irq, 1'b0);
    reg_rd(2'd0, r); chk("R9 sbc pending bit", r[9], 1'b1);
    reg_wr(2'd0, 16'h0006);
    chk("R10 irq from sbc", irq, 1'b1);
    sbc_irq = 1'b0;
    #1; chk("R10 irq drops with sbc", irq, 1'b0);
    run_rx(2);
    reg_wr(2'd0, 16'h0007);
    chk("R10 irq from dma pending", irq, 1'b1);
    reg_wr(2'd1, 16'd0);
    reg_rd(2'd0, r); chk("R9 count write clears pending", r[8], 1'b0);
    chk("R10 irq cleared", irq, 1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule